// File: doc/BRIEF.md
# Infrared Receive Buffer with Event Interrupt

This block sits between an infrared line sampler and a processor bus. The sampler hands it one byte per measured run (a run-length code) and a one-cycle marker when a burst of activity ends. The block queues the codes in a 16-deep byte buffer. It keeps three sticky event flags: buffer overflow, end of packet, and data waiting above a programmable threshold. It raises a single level-sensitive interrupt line for any flag whose enable is set.

Software reaches the block through a simple single-cycle register port with select, write, address and data. Read data appears one cycle after the access. Reading the data register takes one byte off the head of the buffer. Reading the status register returns the live fill count next to the event flags, and writing ones to the status register clears the flags. A control register switches the receive path on, and two configuration registers hold settings that the block passes straight through to the sampler.

Top module: `ir_rx_buffer`

## Requirements
- R1: After reset every register reads zero, the buffer is empty and `irq` is low.
- R2: A read at offset 0x20 returns the oldest queued byte in bits 7:0 with zeros above, and removes that byte. Bytes come out in the order they were accepted.
- R3: A code that arrives while 16 bytes are held and no read is removing one is dropped, and status bit 0 (overflow) becomes 1. The 16 held bytes are kept unchanged.
- R4: A read at offset 0x20 while the buffer is empty returns 0 and leaves the fill count at 0.
- R5: Status (offset 0x30) bits 13:8 always give the number of bytes currently held.
- R6: A packet-end marker accepted by the receiver sets status bit 1.
- R7: Status bit 4 (data waiting) becomes 1 when the fill count is greater than the level field in bits 11:8 of the interrupt-enable register (offset 0x2C). With level 7, it first becomes 1 at 8 held bytes and stays 0 at 7.
- R8: A write to the status register clears each event flag whose bit in the write data is 1 and leaves flags with a 0 bit alone. Writing 0xFF clears all three. A set condition that is still present in the same cycle wins over the clear.
- R9: `irq` is high exactly when some status flag at bit 0, 1 or 4 is set and the bit in the same position of the interrupt-enable register is also 1.
- R10: Codes and packet-end markers are accepted only while control (offset 0x00) bits 0 and 1 are both 1. Otherwise they are ignored. Writing 0 to control and to the interrupt-enable register therefore stops reception and holds `irq` low.
- R11: Control reads back bits 0, 1 and 5:4, and bits 5:4 drive `mode_sel`. Interrupt-enable reads back bits 0, 1, 4 and 11:8. Offset 0x10 keeps bits 7:0 and drives `cfg_rx`. Offset 0x34 keeps bits 15:0 and drives `cfg_sample`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sampler presents a run-length code this cycle |
| smp_code | input | 8 | Run-length code from the sampler |
| smp_pkt_end | input | 1 | One-cycle end-of-packet marker from the sampler |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read access |
| irq | output | 1 | Level-sensitive interrupt |
| rx_active | output | 1 | Receive path enabled (control bits 0 and 1 both set) |
| mode_sel | output | 2 | Mode field from control bits 5:4 |
| cfg_rx | output | 8 | Receive configuration for the sampler |
| cfg_sample | output | 16 | Sample configuration for the sampler |

## Verification
The bench fills the buffer to exactly 16 and then offers a seventeenth code. A design with an off-by-one in its full test would either accept the extra byte and overwrite the head, or refuse the sixteenth. It sets the level to 7 and checks the data-waiting flag at 7 and at 8 bytes. A design comparing with greater-or-equal, or ignoring the minus-one encoding, flags one byte early or late. It also clears a flag while its cause persists and clears with a mask that misses a flag. A design that lets the clear win, or clears everything on any write, shows a wrong status word. Finally, it reads an empty buffer and feeds codes with the receiver half-enabled. A design that moves a pointer on an empty read, or gates reception on a single control bit, shows a nonzero count.

// File: rtl/ir_rx_pkg.sv
// Shared constants and types for the infrared receive buffer.
// Register offsets and bit positions are fixed by software and must not move.
package ir_rx_pkg;

    // Register byte offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_RXCFG = 'h10;
    localparam int OFS_DATA  = 'h20;
    localparam int OFS_IEN   = 'h2C;
    localparam int OFS_STAT  = 'h30;
    localparam int OFS_SMP   = 'h34;

    // Event flag indices inside the internal flag vector
    localparam int NUM_EVT   = 3;
    localparam int EVT_OVF   = 0;
    localparam int EVT_PKT   = 1;
    localparam int EVT_AVL   = 2;

    // Field positions in status / enable / control words
    localparam int FILL_LSB  = 8;
    localparam int FILL_W    = 6;
    localparam int LVL_LSB   = 8;
    localparam int CTRL_GEN  = 0;
    localparam int CTRL_RXEN = 1;
    localparam int MODE_LSB  = 4;
    localparam int RXCFG_W   = 8;
    localparam int SMPCFG_W  = 16;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RXCFG,
        SEL_DATA,
        SEL_IEN,
        SEL_STAT,
        SEL_SMP
    } reg_sel_e;

    // Bit position in status/enable words of event index i
    function automatic int evt_bit(input int i);
        case (i)
            EVT_OVF: return 0;
            EVT_PKT: return 1;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ir_rx_fifo.sv
// Byte queue of DEPTH entries with a registered fill count.
// Assumes: push and pop are single-cycle strobes; a pop of an empty queue is
// ignored; a push into a full queue is accepted only if a pop frees a slot
// in the same cycle, otherwise it is dropped and reported on 'drop'.
module ir_rx_fifo #(
    parameter  int DEPTH  = 16,
    parameter  int DATA_W = 8,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  fill,
    output logic              full,
    output logic              empty,
    output logic              drop
);

    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] slot [DEPTH];
    logic              do_push;
    logic              do_pop;

    // Next pointer value with wrap at DEPTH-1
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept decisions for this cycle
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_pop  = pop & ~empty;
        do_push = push & (~full | do_pop);
        drop    = push & ~do_push;
    end

    // One storage register per entry, written when the write pointer hits it
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (do_push && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= push_data;
            end
        end
    end

    // Pointer and count bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head byte, forced to zero when nothing is held
    always_comb begin
        head_data = empty ? '0 : slot[rd_ptr];
        fill      = count;
    end

endmodule

// File: rtl/ir_rx_events.sv
// Sticky event flags and the interrupt line.
// Assumes: set inputs are single-cycle; the data-waiting condition is a
// level taken from the registered fill count. A set and a clear of the same
// flag in one cycle leave it set.
module ir_rx_events
    import ir_rx_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int LVL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_ovf,
    input  logic               set_pkt,
    input  logic [CNT_W-1:0]   fill,
    input  logic [LVL_W-1:0]   level,
    input  logic [NUM_EVT-1:0] clr_vec,
    input  logic [NUM_EVT-1:0] ien_vec,
    output logic [NUM_EVT-1:0] flags,
    output logic               irq
);

    logic [NUM_EVT-1:0] set_vec;

    // Gather set conditions into one vector indexed like the flags
    always_comb begin
        set_vec          = '0;
        set_vec[EVT_OVF] = set_ovf;
        set_vec[EVT_PKT] = set_pkt;
        set_vec[EVT_AVL] = (int'(fill) > int'(level));
    end

    // One sticky flag per event: set wins over write-one-to-clear
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[e] <= 1'b0;
            end else begin
                flags[e] <= set_vec[e] | (flags[e] & ~clr_vec[e]);
            end
        end
    end

    // Level interrupt from enabled flags
    always_comb begin
        irq = |(flags & ien_vec);
    end

endmodule

// File: rtl/ir_rx_regs.sv
// Register decode, configuration storage and registered read data.
// Assumes: one access per cycle; read data is returned the following cycle;
// a read of the data offset asks the queue for a pop in the access cycle.
module ir_rx_regs
    import ir_rx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5,
    parameter int LVL_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [DATA_W-1:0]   head_data,
    input  logic [CNT_W-1:0]    fill,
    input  logic [NUM_EVT-1:0]  flags,
    output logic                pop_req,
    output logic [NUM_EVT-1:0]  clr_vec,
    output logic                ctrl_gen,
    output logic                ctrl_rxen,
    output logic [1:0]          mode_sel,
    output logic [NUM_EVT-1:0]  ien_vec,
    output logic [LVL_W-1:0]    level,
    output logic [RXCFG_W-1:0]  cfg_rx,
    output logic [SMPCFG_W-1:0] cfg_sample
);

    reg_sel_e         sel;
    logic             wr_any;
    logic             rd_any;
    logic [BUS_W-1:0] rd_mux;
    logic [BUS_W-1:0] unused_wdata;

    assign unused_wdata = bus_wdata;

    // Map the byte offset onto a register selector
    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_CTRL):  sel = SEL_CTRL;
            ADDR_W'(OFS_RXCFG): sel = SEL_RXCFG;
            ADDR_W'(OFS_DATA):  sel = SEL_DATA;
            ADDR_W'(OFS_IEN):   sel = SEL_IEN;
            ADDR_W'(OFS_STAT):  sel = SEL_STAT;
            ADDR_W'(OFS_SMP):   sel = SEL_SMP;
            default:            sel = SEL_NONE;
        endcase
        wr_any = bus_sel & bus_wr;
        rd_any = bus_sel & ~bus_wr;
    end

    // Pop strobe and status clear mask for this cycle
    always_comb begin
        pop_req = rd_any && (sel == SEL_DATA);
        clr_vec = '0;
        if (wr_any && (sel == SEL_STAT)) begin
            for (int e = 0; e < NUM_EVT; e++) begin
                clr_vec[e] = bus_wdata[evt_bit(e)];
            end
        end
    end

    // Writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_gen   <= 1'b0;
            ctrl_rxen  <= 1'b0;
            mode_sel   <= '0;
            ien_vec    <= '0;
            level      <= '0;
            cfg_rx     <= '0;
            cfg_sample <= '0;
        end else if (wr_any) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl_gen  <= bus_wdata[CTRL_GEN];
                    ctrl_rxen <= bus_wdata[CTRL_RXEN];
                    mode_sel  <= bus_wdata[MODE_LSB +: 2];
                end
                SEL_IEN: begin
                    for (int e = 0; e < NUM_EVT; e++) begin
                        ien_vec[e] <= bus_wdata[evt_bit(e)];
                    end
                    level <= bus_wdata[LVL_LSB +: LVL_W];
                end
                SEL_RXCFG: cfg_rx     <= bus_wdata[RXCFG_W-1:0];
                SEL_SMP:   cfg_sample <= bus_wdata[SMPCFG_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read multiplexer over all registers
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: begin
                rd_mux[CTRL_GEN]        = ctrl_gen;
                rd_mux[CTRL_RXEN]       = ctrl_rxen;
                rd_mux[MODE_LSB +: 2]   = mode_sel;
            end
            SEL_RXCFG: rd_mux[RXCFG_W-1:0]  = cfg_rx;
            SEL_DATA:  rd_mux[DATA_W-1:0]   = head_data;
            SEL_IEN: begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    rd_mux[evt_bit(e)] = ien_vec[e];
                end
                rd_mux[LVL_LSB +: LVL_W] = level;
            end
            SEL_STAT: begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    rd_mux[evt_bit(e)] = flags[e];
                end
                rd_mux[FILL_LSB +: FILL_W] = FILL_W'(fill);
            end
            SEL_SMP:  rd_mux[SMPCFG_W-1:0] = cfg_sample;
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_any) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/ir_rx_buffer.sv
// Top of the infrared receive buffer: gates sampler input with the receive
// enable, queues codes, keeps event flags and drives the interrupt.
// Assumes: sampler strobes are synchronous to clk; one bus access per cycle.
module ir_rx_buffer
    import ir_rx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32,
    parameter int LVL_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_code,
    input  logic                smp_pkt_end,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic                irq,
    output logic                rx_active,
    output logic [1:0]          mode_sel,
    output logic [RXCFG_W-1:0]  cfg_rx,
    output logic [SMPCFG_W-1:0] cfg_sample
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               ctrl_gen;
    logic               ctrl_rxen;
    logic               push_req;
    logic               pkt_req;
    logic               pop_req;
    logic               fifo_full;
    logic               fifo_empty;
    logic               fifo_drop;
    logic [DATA_W-1:0]  head_data;
    logic [CNT_W-1:0]   fill_count;
    logic [NUM_EVT-1:0] evt_flags;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] ien_vec;
    logic [LVL_W-1:0]   level;

    // Receive path gating from both control enables
    always_comb begin
        rx_active = ctrl_gen & ctrl_rxen;
        push_req  = smp_valid & rx_active;
        pkt_req   = smp_pkt_end & rx_active;
    end

    ir_rx_regs #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W),
        .CNT_W(CNT_W), .LVL_W(LVL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .head_data(head_data), .fill(fill_count), .flags(evt_flags),
        .pop_req(pop_req), .clr_vec(clr_vec),
        .ctrl_gen(ctrl_gen), .ctrl_rxen(ctrl_rxen), .mode_sel(mode_sel),
        .ien_vec(ien_vec), .level(level),
        .cfg_rx(cfg_rx), .cfg_sample(cfg_sample)
    );

    ir_rx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_req), .push_data(smp_code), .pop(pop_req),
        .head_data(head_data), .fill(fill_count),
        .full(fifo_full), .empty(fifo_empty), .drop(fifo_drop)
    );

    ir_rx_events #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_events (
        .clk(clk), .rst_n(rst_n),
        .set_ovf(fifo_drop), .set_pkt(pkt_req),
        .fill(fill_count), .level(level),
        .clr_vec(clr_vec), .ien_vec(ien_vec),
        .flags(evt_flags), .irq(irq)
    );

endmodule

// File: rtl/ir_rx_buffer_chk.sv
// Property checker for the infrared receive buffer, bound to the top.
module ir_rx_buffer_chk
    import ir_rx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic               smp_pkt_end,
    input logic               rx_active,
    input logic               pop_req,
    input logic               fifo_full,
    input logic               fifo_empty,
    input logic [CNT_W-1:0]   fill_count,
    input logic [NUM_EVT-1:0] evt_flags,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic               irq
);

    // R5: fill count never exceeds capacity
    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= DEPTH);

    // R3: a code arriving at a full buffer with no pop raises overflow
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rx_active && fifo_full && !pop_req) |=> evt_flags[EVT_OVF]);

    // R3: the dropped code does not change the count
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rx_active && fifo_full && !pop_req) |=> (int'(fill_count) == DEPTH));

    // R2: an accepted code with no pop grows the count by one
    assert_push_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rx_active && !fifo_full && !pop_req)
        |=> (fill_count == $past(fill_count) + 1'b1));

    // R4: a read of an empty buffer with no push leaves it empty
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && fifo_empty && !(smp_valid && rx_active)) |=> (fill_count == '0));

    // R6: an accepted packet end sets its flag
    assert_pkt_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_pkt_end && rx_active) |=> evt_flags[EVT_PKT]);

    // R10: a code offered while disabled does not change the count
    assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !rx_active && !pop_req) |=> $stable(fill_count));

    // R9: writing zero to the enable register forces the interrupt low
    assert_ien_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_IEN)) && (bus_wdata == '0))
        |=> !irq);

endmodule

bind ir_rx_buffer ir_rx_buffer_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_pkt_end(smp_pkt_end), .rx_active(rx_active),
    .pop_req(pop_req), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .fill_count(fill_count), .evt_flags(evt_flags),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/sim_ir_rx_buffer.sv
// Directed bench for the infrared receive buffer.
module sim_ir_rx_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_code = '0;
    logic        smp_pkt_end = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_active;
    logic [1:0]  mode_sel;
    logic [7:0]  cfg_rx;
    logic [15:0] cfg_sample;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_RXCFG = 8'h10, A_DATA = 8'h20,
                           A_IEN  = 8'h2C, A_STAT  = 8'h30, A_SMP  = 8'h34;

    always #2.5 clk = ~clk;

    ir_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .smp_valid(smp_valid), .smp_code(smp_code), .smp_pkt_end(smp_pkt_end),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_active(rx_active), .mode_sel(mode_sel),
        .cfg_rx(cfg_rx), .cfg_sample(cfg_sample)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk);
        smp_valid = 1'b1; smp_code = c;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pkt_end();
        @(negedge clk);
        smp_pkt_end = 1'b1;
        @(negedge clk);
        smp_pkt_end = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_STAT, v); check("R1 status", v, 32'h0);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_IEN, v);  check("R1 ien", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R11 ctrl readback", v, 32'h33);
        check("R11 mode_sel", {30'b0, mode_sel}, 32'h3);
        wr(A_IEN, 32'hFFFF_FFFF);  rd(A_IEN, v);  check("R11 ien readback", v, 32'h0F13);
        wr(A_RXCFG, 32'hFFFF_FFA5); rd(A_RXCFG, v); check("R11 rxcfg readback", v, 32'hA5);
        check("R11 cfg_rx", {24'b0, cfg_rx}, 32'hA5);
        wr(A_SMP, 32'hDEAD_1234); rd(A_SMP, v); check("R11 smp readback", v, 32'h1234);
        check("R11 cfg_sample", {16'b0, cfg_sample}, 32'h1234);
        wr(A_IEN, 32'h0); wr(A_CTRL, 32'h3); wr(A_STAT, 32'hFF);
    endtask

    task automatic t_order();
        logic [31:0] v;
        logic [7:0] pat [5] = '{8'h81, 8'h05, 8'hFE, 8'h40, 8'h7F};
        for (int i = 0; i < 5; i++) push(pat[i]);
        idle(2);
        rd(A_STAT, v); check("R5 count five", v & 32'h3F00, 32'h0500);
        for (int i = 0; i < 5; i++) begin
            rd(A_DATA, v); check("R2 order", v, {24'b0, pat[i]});
        end
        rd(A_STAT, v); check("R5 count zero", v & 32'h3F00, 32'h0);
        wr(A_STAT, 32'hFF);
    endtask

    task automatic t_empty();
        logic [31:0] v;
        rd(A_DATA, v); check("R4 empty read", v, 32'h0);
        rd(A_DATA, v); check("R4 empty read again", v, 32'h0);
        rd(A_STAT, v); check("R4 count stays zero", v & 32'h3F00, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(A_IEN, 32'h700);
        for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
        idle(2);
        rd(A_STAT, v); check("R7 seven held no flag", v & 32'h3F10, 32'h0700);
        push(8'h17); idle(2);
        rd(A_STAT, v); check("R7 eight held flag", v & 32'h3F10, 32'h0810);
        check("R9 masked irq low", {31'b0, irq}, 32'h0);
        wr(A_IEN, 32'h710); idle(1);
        check("R9 enabled irq high", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h10); idle(2);
        rd(A_STAT, v); check("R8 clear loses to live cause", v & 32'h10, 32'h10);
        rd(A_DATA, v); check("R2 head after level", v, 32'h10);
        wr(A_STAT, 32'h10); idle(2);
        rd(A_STAT, v); check("R8 clear at seven", v & 32'h3F10, 32'h0700);
        check("R9 irq drops", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 7; i++) rd(A_DATA, v);
        wr(A_IEN, 32'h0); wr(A_STAT, 32'hFF);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wr(A_IEN, 32'h001); wr(A_STAT, 32'hFF);
        for (int i = 0; i < 17; i++) push(8'h20 + 8'(i));
        idle(2);
        rd(A_STAT, v); check("R3 full with overflow", v & 32'h3F03, 32'h1001);
        check("R9 overflow irq", {31'b0, irq}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(A_DATA, v); check("R3 kept bytes", v, 32'h20 + 32'(i));
        end
        rd(A_DATA, v); check("R3 extra byte dropped", v, 32'h0);
        wr(A_STAT, 32'h01); idle(1);
        rd(A_STAT, v); check("R8 overflow cleared", v & 32'h01, 32'h0);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'hFF);
    endtask

    task automatic t_pktend();
        logic [31:0] v;
        wr(A_IEN, 32'h002);
        pkt_end(); idle(1);
        rd(A_STAT, v); check("R6 packet end flag", v & 32'h02, 32'h02);
        check("R9 packet irq", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h01); idle(1);
        rd(A_STAT, v); check("R8 zero bit keeps flag", v & 32'h02, 32'h02);
        wr(A_STAT, 32'hFF); idle(1);
        rd(A_STAT, v); check("R8 clear all", v, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(A_CTRL, 32'h1); push(8'h55); pkt_end(); idle(2);
        rd(A_STAT, v); check("R10 gen only ignored", v, 32'h0);
        wr(A_CTRL, 32'h2); push(8'h56); pkt_end(); idle(2);
        rd(A_STAT, v); check("R10 rxen only ignored", v, 32'h0);
        wr(A_CTRL, 32'h3); wr(A_IEN, 32'h013); push(8'h66); idle(2);
        check("R9 data waiting irq", {31'b0, irq}, 32'h1);
        wr(A_IEN, 32'h0); wr(A_CTRL, 32'h0); idle(1);
        check("R10 irq off after disable", {31'b0, irq}, 32'h0);
        push(8'h77); pkt_end(); idle(2);
        rd(A_STAT, v); check("R10 disabled ignores input", v & 32'h3F03, 32'h0100);
        rd(A_DATA, v); check("R10 only enabled byte held", v, 32'h66);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_config();
        t_order();
        t_empty();
        t_level();
        t_overflow();
        t_pktend();
        t_disable();
        idle(2);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule